// File: doc/BRIEF.md
# Batch Integer Square Root Engine

This block computes the integer square root of each value in a list of unsigned 32-bit words held in an external word-addressed RAM. The word at address 0 gives the number of operands N. The operands sit at addresses 1 through N, and each result overwrites its own operand in place. A one-cycle `start` pulse begins a run. When the list is exhausted, the engine raises `done` and keeps it high until the next `start`.

Each root comes from Heron's iteration. The first estimate is half the operand. Each step replaces the estimate x with (x + s/x)/2, and the loop stops once the previous estimate is no longer larger than the new one. Operands of 0 and 1 skip the loop and are stored unchanged. A sixteen-state encoded controller sequences every bus access and every step of the loop. A combinational divider finishes each division state in one clock.

The engine and the RAM share one 32-bit data bus. The RAM drives the bus while `rd_en` is high, and the engine drives it only while `wr_en` is high. Each read keeps `rd_en` and the address steady for two cycles: in the first the address is presented, and in the second the data is captured. A write is one cycle long, and the RAM takes the word on the rising edge.

Top module: `isqrt_batch`

## Requirements
- R1: While reset is high and in the cycle after it, `rd_en`, `wr_en` and `done` are all 0.
- R2: A `start` pulse seen in the idle or finished state makes `rd_en` high with `abus` = 0 in the next cycle. The address and `rd_en` then hold for a second cycle.
- R3: A count word of 0 ends the run with `done` high and no write to the RAM.
- R4: For N operands at addresses 1..N, each address ends up holding floor(sqrt(operand)). The word at address N+1 is left unchanged.
- R5: Operands 0 and 1 are written back as 0 and 1.
- R6: Roots are exact across the full 32-bit range, for example 0xFFFFFFFF gives 65535, 0xFFFE0001 gives 65535 and 0xFFFE0000 gives 65534.
- R7: `done` stays high until the next `start`. A new `start` clears it in the following cycle and begins a fresh run.
- R8: `rd_en` and `wr_en` are never high together. Exactly one write is made per operand, and only to addresses 1..N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a run |
| dbus | inout | 32 | Shared data bus; driven by the engine only while `wr_en` is high |
| abus | output | 32 | Word address for RAM reads and writes |
| rd_en | output | 1 | RAM read request; the RAM drives `dbus` while high |
| wr_en | output | 1 | RAM write strobe; the RAM stores `dbus` on the rising edge |
| done | output | 1 | High when the whole list has been processed |

## Verification
A controller stuck in or skipping a state shows up at the ports within a few cycles. The fetch of address 0 appears, or fails to appear, one cycle after `start`. A broken loop exit or estimate update leaves a wrong word in RAM, or makes `done` late or missing, at most a few hundred cycles into one operand. An address or count slip shows as a write to address 0, a write past N, or a touched sentinel word. Each of these is checked directly against a bit-serial root computed in the bench.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;

    parameter int WORD_W = 32;
    parameter int ADDR_W = 32;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_CNT_A = 4'd1,
        ST_CNT_D = 4'd2,
        ST_CHK_N = 4'd3,
        ST_OP_A  = 4'd4,
        ST_OP_D  = 4'd5,
        ST_CHK_S = 4'd6,
        ST_INIT  = 4'd7,
        ST_DIV_1 = 4'd8,
        ST_DIV_2 = 4'd9,
        ST_DIV_3 = 4'd10,
        ST_CMP_1 = 4'd11,
        ST_CMP_2 = 4'd12,
        ST_STORE = 4'd13,
        ST_DEC   = 4'd14,
        ST_DONE  = 4'd15
    } state_e;

    typedef struct packed {
        word_t             cnt;
        addr_t             addr;
        word_t             s;
        word_t             x;
        word_t             q;
        logic [WORD_W:0]   sum;
        word_t             xn;
        word_t             res;
        logic              le;
    } dp_t;

    function automatic logic is_trivial(input word_t v);
        return v <= word_t'(1);
    endfunction

    function automatic word_t first_guess(input word_t v);
        return v >> 1;
    endfunction

    function automatic logic is_read_state(input state_e st);
        return (st == ST_CNT_A) || (st == ST_CNT_D) ||
               (st == ST_OP_A)  || (st == ST_OP_D);
    endfunction

endpackage

// File: rtl/isqrt_step.sv
module isqrt_step
    import isqrt_pkg::*;
(
    input  word_t           s_i,
    input  word_t           x_i,
    input  word_t           q_i,
    input  logic [WORD_W:0] sum_i,
    output word_t           q_o,
    output logic [WORD_W:0] sum_o,
    output word_t           avg_o
);
    always_comb begin
        if (x_i == '0) q_o = '1;
        else           q_o = s_i / x_i;
    end

    assign sum_o = {1'b0, x_i} + {1'b0, q_i};
    assign avg_o = sum_i[WORD_W:1];
endmodule

// File: rtl/isqrt_fsm.sv
module isqrt_fsm
    import isqrt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   cnt_zero,
    input  logic   s_trivial,
    input  logic   converged,
    output state_e state
);
    state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_CNT_A;
            ST_CNT_A: nxt = ST_CNT_D;
            ST_CNT_D: nxt = ST_CHK_N;
            ST_CHK_N: nxt = cnt_zero ? ST_DONE : ST_OP_A;
            ST_OP_A:  nxt = ST_OP_D;
            ST_OP_D:  nxt = ST_CHK_S;
            ST_CHK_S: nxt = s_trivial ? ST_STORE : ST_INIT;
            ST_INIT:  nxt = ST_DIV_1;
            ST_DIV_1: nxt = ST_DIV_2;
            ST_DIV_2: nxt = ST_DIV_3;
            ST_DIV_3: nxt = ST_CMP_1;
            ST_CMP_1: nxt = ST_CMP_2;
            ST_CMP_2: nxt = converged ? ST_STORE : ST_DIV_1;
            ST_STORE: nxt = ST_DEC;
            ST_DEC:   nxt = ST_CHK_N;
            ST_DONE:  if (start) nxt = ST_CNT_A;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/isqrt_dp.sv
module isqrt_dp
    import isqrt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  state_e state,
    input  word_t  rdata,
    output dp_t    dp
);
    word_t           q_w;
    logic [WORD_W:0] sum_w;
    word_t           avg_w;

    isqrt_step u_step (
        .s_i   (dp.s),
        .x_i   (dp.x),
        .q_i   (dp.q),
        .sum_i (dp.sum),
        .q_o   (q_w),
        .sum_o (sum_w),
        .avg_o (avg_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dp <= '0;
        end else begin
            unique case (state)
                ST_CNT_D: begin
                    dp.cnt  <= rdata;
                    dp.addr <= addr_t'(1);
                end
                ST_OP_D:  dp.s <= rdata;
                ST_CHK_S: if (is_trivial(dp.s)) dp.res <= dp.s;
                ST_INIT:  dp.x <= first_guess(dp.s);
                ST_DIV_1: dp.q <= q_w;
                ST_DIV_2: dp.sum <= sum_w;
                ST_DIV_3: dp.xn <= avg_w;
                ST_CMP_1: dp.le <= (dp.x <= dp.xn);
                ST_CMP_2: begin
                    if (dp.le) dp.res <= dp.x;
                    else       dp.x   <= dp.xn;
                end
                ST_DEC: begin
                    dp.cnt  <= dp.cnt - word_t'(1);
                    dp.addr <= dp.addr + addr_t'(1);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/isqrt_batch.sv
module isqrt_batch
    import isqrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    inout  wire  [WORD_W-1:0] dbus,
    output logic [ADDR_W-1:0] abus,
    output logic              rd_en,
    output logic              wr_en,
    output logic              done
);
    state_e state;
    dp_t    dp;
    logic   cnt_phase;

    isqrt_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cnt_zero  (dp.cnt == '0),
        .s_trivial (is_trivial(dp.s)),
        .converged (dp.le),
        .state     (state)
    );

    isqrt_dp u_dp (
        .clk   (clk),
        .rst   (rst),
        .state (state),
        .rdata (dbus),
        .dp    (dp)
    );

    assign cnt_phase = (state == ST_CNT_A) || (state == ST_CNT_D);
    assign rd_en     = is_read_state(state);
    assign wr_en     = (state == ST_STORE);
    assign done      = (state == ST_DONE);
    assign abus      = cnt_phase ? '0 : dp.addr;
    assign dbus      = wr_en ? dp.res : 'z;
endmodule

// File: rtl/isqrt_batch_chk.sv
module isqrt_batch_chk
    import isqrt_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   start,
    input addr_t  abus,
    input logic   rd_en,
    input logic   wr_en,
    input logic   done,
    input state_e state
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!rd_en && !wr_en && !done)); // R1

    AST_COUNT_FETCH: assert property (@(posedge clk) disable iff (rst)
        (start && (state == ST_IDLE || state == ST_DONE)) |=> (rd_en && abus == '0)); // R2

    AST_READ_HELD: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_en) |=> (rd_en && $stable(abus))); // R2

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done); // R7

    AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en)); // R8

    AST_NO_COUNT_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (abus != '0)); // R8
endmodule

bind isqrt_batch isqrt_batch_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .abus  (abus),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .done  (done),
    .state (state)
);

// File: tb/sim_isqrt_batch.sv
`timescale 1ns/1ps
module sim_isqrt_batch;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    wire  [31:0] dbus;
    logic [31:0] abus;
    logic        rd_en, wr_en, done;

    logic [31:0] mem [0:63];
    logic        tb_we = 1'b0;
    logic [5:0]  tb_a = '0;
    logic [31:0] tb_d = '0;

    int checks = 0;
    int errors = 0;
    int writes = 0;
    int bad_wr = 0;
    int overlap = 0;
    int cur_n = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    isqrt_batch u0 (
        .clk(clk), .rst(rst), .start(start), .dbus(dbus),
        .abus(abus), .rd_en(rd_en), .wr_en(wr_en), .done(done)
    );

    assign dbus = rd_en ? mem[abus[5:0]] : 'z;

    always @(posedge clk) begin
        if (wr_en) begin
            mem[abus[5:0]] <= dbus;
            writes <= writes + 1;
            if (abus == 0 || int'(abus) > cur_n) bad_wr <= bad_wr + 1;
        end else if (tb_we) begin
            mem[tb_a] <= tb_d;
        end
        if (rd_en && wr_en) overlap <= overlap + 1;
    end

    function automatic logic [31:0] ref_root(input logic [31:0] v);
        logic [31:0] r = 0;
        for (int b = 15; b >= 0; b--) begin
            logic [31:0] t = r | (32'd1 << b);
            if (64'(t) * 64'(t) <= 64'(v)) r = t;
        end
        return r;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_a = 6'(a); tb_d = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(rd_en && abus == 0, "R2 count fetch first cycle", abus, 0);
        chk(!done, "R7 done cleared by start", 32'(done), 0);
        @(negedge clk);
        chk(rd_en && abus == 0, "R2 count fetch held", abus, 0);
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done, tag, 32'(done), 1);
    endtask

    task automatic run_list(input logic [31:0] ops[], input string tag);
        logic [31:0] sentinel = 32'hA5A5_0000 + 32'(ops.size());
        cur_n = ops.size();
        poke(0, 32'(ops.size()));
        foreach (ops[i]) poke(i + 1, ops[i]);
        poke(ops.size() + 1, sentinel);
        writes = 0;
        pulse_start();
        wait_done({tag, " done"});
        foreach (ops[i])
            chk(mem[i+1] == ref_root(ops[i]), tag, mem[i+1], ref_root(ops[i]));
        chk(mem[ops.size()+1] == sentinel, "R4 word past list untouched", mem[ops.size()+1], sentinel);
        chk(writes == ops.size(), "R8 one write per operand", 32'(writes), 32'(ops.size()));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!rd_en && !wr_en && !done, "R1 outputs quiet in reset", {rd_en, wr_en, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!rd_en && !wr_en && !done, "R1 outputs quiet after reset", {rd_en, wr_en, done}, 0);
    endtask

    task automatic t_zero_count();
        logic [31:0] none[];
        none = new[0];
        cur_n = 0;
        poke(0, 0);
        poke(1, 32'd77);
        writes = 0;
        pulse_start();
        wait_done("R3 zero count finishes");
        chk(writes == 0, "R3 no write for empty list", 32'(writes), 0);
        chk(mem[1] == 32'd77, "R3 operand slot untouched", mem[1], 77);
    endtask

    task automatic t_small();
        logic [31:0] ops[] = '{32'd4, 32'd0, 32'd1, 32'd2, 32'd3, 32'd5, 32'd99};
        run_list(ops, "R4 R5 small operands");
        chk(mem[2] == 0 && mem[3] == 1, "R5 trivial operands kept", {mem[2][15:0], mem[3][15:0]}, 32'h0000_0001);
    endtask

    task automatic t_large();
        logic [31:0] ops[] = '{32'hFFFF_FFFF, 32'hFFFE_0001, 32'hFFFE_0000,
                               32'd1000000, 32'h8000_0000, 32'd15};
        run_list(ops, "R6 wide operands");
        chk(mem[1] == 32'd65535, "R6 all ones", mem[1], 65535);
        chk(mem[3] == 32'd65534, "R6 square minus one", mem[3], 65534);
    endtask

    task automatic t_hold_restart();
        logic [31:0] ops[] = '{32'd16};
        repeat (12) @(negedge clk);
        chk(done, "R7 done held while idle", 32'(done), 1);
        run_list(ops, "R7 restart after done");
    endtask

    initial begin
        t_reset();
        t_zero_count();
        t_small();
        t_large();
        t_hold_restart();
        chk(overlap == 0, "R8 read and write never together", 32'(overlap), 0);
        chk(bad_wr == 0, "R8 writes only inside list", 32'(bad_wr), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule